// File: doc/BRIEF.md
# Multithreaded Issue Slot Allocator

This block decides, once per clock, which ready instructions of a shared scheduling window go out through the issue slots of a multithreaded core. The window holds 32 candidate entries. Every entry has a valid bit, a ready bit, a 3-bit thread number, an age tag, a branch flag and a speculative flag. All threads compete for the same eight slots. The block fills the slots in priority order and returns one one-hot entry index per slot, each with a slot-valid bit.

Two inputs control the selection. The cap input limits how many slots a single thread may take in one cycle: one, two, four, or no limit. The ordering input chooses the priority rule. The default rule takes the oldest entries first. Optional rules move branches ahead of other work and push speculative work behind everything else. The grants are registered, so they appear one clock after the window contents they were computed from. Execution, register read, and filling or draining the window belong to other blocks.

Top module: `issue_alloc`

## Requirements
- R1: While reset is held, and for the cycles before the first grant is computed, every slot-valid bit is 0 and every grant vector is all zeros.
- R2: Only an entry with both valid and ready set can be granted. Each slot's grant vector has at most one bit set, and no entry appears in more than one slot in the same cycle. A slot-valid bit is 1 exactly when that slot's vector is non-zero.
- R3: Slots fill from slot 0 upward with no gaps. The number of valid slots is the smaller of eight and the number of entries that can be granted under the cap.
- R4: cap_mode encodes the per-thread limit per cycle: 2'b00 allows one grant, 2'b01 two, 2'b10 four, and 2'b11 removes the limit, so one thread can take all eight slots.
- R5: With order_mode 2'b00, a smaller age tag means an older entry, and older entries are granted first. Slot 0 gets the best entry. Among entries with equal age tags, the lower window index wins.
- R6: order_mode bit 0 set (branch-first): ready branch entries are granted before all non-branch entries. Age and then index order the entries inside each group.
- R7: order_mode bit 1 set (speculative-last): speculative entries are granted only after all non-speculative candidates. With both bits set, speculative status is the major key and the branch group is the minor key. Age and then index decide after that.
- R8: When a thread has reached its cap, its remaining entries are skipped, and the following slots go to the next best entries of other threads.
- R9: Grants for the window contents present before a rising clock edge appear on the outputs just after that edge, and not earlier.
- R10: With a cap of two, ready work from three threads fills at most six slots. Four threads with enough ready work fill all eight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ent_valid | input | 32 | Entry holds an instruction |
| ent_ready | input | 32 | Entry operands are ready |
| ent_tid | input | 96 | Thread number per entry, 3 bits each, entry i at [3i+:3] |
| ent_age | input | 160 | Age tag per entry, 5 bits each, entry i at [5i+:5]; smaller is older |
| ent_branch | input | 32 | Entry is a branch |
| ent_spec | input | 32 | Entry is speculative |
| cap_mode | input | 2 | Per-thread per-cycle issue limit selector |
| order_mode | input | 2 | Bit 0 branch-first, bit 1 speculative-last |
| slot_vld | output | 8 | Slot k carries a grant |
| slot_grant | output | 256 | One-hot entry index per slot, slot k at [32k+:32] |

## Verification
The assertions assume that the window contents stay stable over a clock edge and that the age tags form a consistent order. They hold for any combination of valid, ready, thread, flag and mode values. The checker keeps its own registered copy of the inputs, so it always compares the outputs against the window that produced them. The directed stimulus changes inputs only on the falling clock edge and reads the grants one falling edge later. It uses distinct or deliberately tied age tags, and thread layouts picked so that each cap setting produces a known skip pattern.

// File: rtl/issue_alloc_pkg.sv
package issue_alloc_pkg;
  localparam int unsigned NUM_ENT  = 32;
  localparam int unsigned NUM_SLOT = 8;
  localparam int unsigned TID_W    = 3;
  localparam int unsigned AGE_W    = 5;

  typedef enum logic [1:0] {
    CAP_ONE  = 2'b00,
    CAP_TWO  = 2'b01,
    CAP_FOUR = 2'b10,
    CAP_ALL  = 2'b11
  } cap_e;

  // per-thread issue limit for a cap selector, nslot meaning unlimited
  function automatic int unsigned cap_limit(input logic [1:0] sel, input int unsigned nslot);
    case (cap_e'(sel))
      CAP_ONE:  return 1;
      CAP_TWO:  return 2;
      CAP_FOUR: return 4;
      default:  return nslot;
    endcase
  endfunction
endpackage

// File: rtl/issue_rank.sv
// Pairwise precedence matrix: beats[i][j] means entry i is preferred over j.
module issue_rank #(
  parameter int unsigned NE  = 32,
  parameter int unsigned AW  = 5
) (
  input  logic [NE-1:0]          br,
  input  logic [NE-1:0]          spec,
  input  logic [NE*AW-1:0]       age,
  input  logic [1:0]             order,
  output logic [NE-1:0][NE-1:0]  beats
);
  localparam int unsigned KW = AW + 2;

  logic [NE-1:0][KW-1:0] key;

  always_comb begin
    for (int i = 0; i < NE; i++) begin
      key[i] = {order[1] & spec[i], order[0] & ~br[i], age[i*AW +: AW]};
    end
  end

  always_comb begin
    for (int i = 0; i < NE; i++) begin
      for (int j = 0; j < NE; j++) begin
        if (i == j) begin
          beats[i][j] = 1'b1;
        end else begin
          beats[i][j] = (key[i] < key[j]) || ((key[i] == key[j]) && (i < j));
        end
      end
    end
  end
endmodule

// File: rtl/issue_slot_pick.sv
// One slot: choose the best eligible entry and update per-thread counts.
module issue_slot_pick #(
  parameter int unsigned NE = 32,
  parameter int unsigned NT = 8,
  parameter int unsigned TW = 3,
  parameter int unsigned CW = 4
) (
  input  logic [NE-1:0]          avail_in,
  input  logic [NE*TW-1:0]       tid,
  input  logic [NE-1:0][NE-1:0]  beats,
  input  logic [CW-1:0]          cap,
  input  logic [NT-1:0][CW-1:0]  cnt_in,
  output logic [NE-1:0]          win,
  output logic                   vld,
  output logic [NE-1:0]          avail_out,
  output logic [NT-1:0][CW-1:0]  cnt_out
);
  logic [NE-1:0] elig;
  logic [TW-1:0] win_tid;

  always_comb begin
    for (int i = 0; i < NE; i++) begin
      elig[i] = avail_in[i] && (cnt_in[tid[i*TW +: TW]] < cap);
    end
    for (int i = 0; i < NE; i++) begin
      win[i] = elig[i] && (&(beats[i] | ~elig));
    end
    vld     = |win;
    win_tid = '0;
    for (int i = 0; i < NE; i++) begin
      if (win[i]) win_tid = win_tid | tid[i*TW +: TW];
    end
    cnt_out = cnt_in;
    if (vld) cnt_out[win_tid] = cnt_in[win_tid] + 1'b1;
    avail_out = avail_in & ~win;
  end
endmodule

// File: rtl/issue_alloc.sv
module issue_alloc
  import issue_alloc_pkg::*;
#(
  parameter int unsigned NE = NUM_ENT,
  parameter int unsigned NS = NUM_SLOT,
  parameter int unsigned TW = TID_W,
  parameter int unsigned AW = AGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NE-1:0]     ent_valid,
  input  logic [NE-1:0]     ent_ready,
  input  logic [NE*TW-1:0]  ent_tid,
  input  logic [NE*AW-1:0]  ent_age,
  input  logic [NE-1:0]     ent_branch,
  input  logic [NE-1:0]     ent_spec,
  input  logic [1:0]        cap_mode,
  input  logic [1:0]        order_mode,
  output logic [NS-1:0]     slot_vld,
  output logic [NS*NE-1:0]  slot_grant
);
  localparam int unsigned NT = 1 << TW;
  localparam int unsigned CW = $clog2(NS + 1);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic [CW-1:0] cap_val;
  always_comb cap_val = CW'(cap_limit(cap_mode, NS));

  logic [NE-1:0][NE-1:0] beats;

  issue_rank #(.NE(NE), .AW(AW)) i_rank (
    .br    (ent_branch),
    .spec  (ent_spec),
    .age   (ent_age),
    .order (order_mode),
    .beats (beats)
  );

  logic [NE-1:0]         avail_c [NS+1];
  logic [NT-1:0][CW-1:0] cnt_c   [NS+1];
  logic [NS-1:0][NE-1:0] grant_d;
  logic [NS-1:0]         vld_d;

  assign avail_c[0] = ent_valid & ent_ready;
  assign cnt_c[0]   = '0;

  for (genvar s = 0; s < NS; s++) begin : g_slot
    issue_slot_pick #(.NE(NE), .NT(NT), .TW(TW), .CW(CW)) i_pick (
      .avail_in  (avail_c[s]),
      .tid       (ent_tid),
      .beats     (beats),
      .cap       (cap_val),
      .cnt_in    (cnt_c[s]),
      .win       (grant_d[s]),
      .vld       (vld_d[s]),
      .avail_out (avail_c[s+1]),
      .cnt_out   (cnt_c[s+1])
    );
  end

  logic                  upd_en;
  logic [NS-1:0][NE-1:0] grant_q;
  logic [NS-1:0]         vld_q;

  assign upd_en = rst_int_n;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      grant_q <= '0;
      vld_q   <= '0;
    end else if (upd_en) begin
      grant_q <= grant_d;
      vld_q   <= vld_d;
    end
  end

  assign slot_vld   = vld_q;
  assign slot_grant = grant_q;
endmodule

// File: rtl/issue_alloc_chk.sv
module issue_alloc_chk
  import issue_alloc_pkg::*;
#(
  parameter int unsigned NE = NUM_ENT,
  parameter int unsigned NS = NUM_SLOT,
  parameter int unsigned TW = TID_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NE-1:0]     ent_valid,
  input logic [NE-1:0]     ent_ready,
  input logic [NE*TW-1:0]  ent_tid,
  input logic [1:0]        cap_mode,
  input logic [NS-1:0]     slot_vld,
  input logic [NS*NE-1:0]  slot_grant
);
  localparam int unsigned NT = 1 << TW;

  logic [NE-1:0]    elig_q;
  logic [NE*TW-1:0] tid_q;
  logic [1:0]       cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elig_q <= '0;
      tid_q  <= '0;
      cap_q  <= 2'b00;
    end else begin
      elig_q <= ent_valid & ent_ready;
      tid_q  <= ent_tid;
      cap_q  <= cap_mode;
    end
  end

  logic [NE-1:0] any_grant;
  int            bit_sum;
  int            thr_cnt [NT];
  logic          cap_ok;

  always_comb begin
    any_grant = '0;
    bit_sum   = 0;
    for (int s = 0; s < NS; s++) begin
      any_grant = any_grant | slot_grant[s*NE +: NE];
      bit_sum   = bit_sum + $countones(slot_grant[s*NE +: NE]);
    end
    for (int t = 0; t < NT; t++) thr_cnt[t] = 0;
    for (int i = 0; i < NE; i++) begin
      if (any_grant[i]) thr_cnt[tid_q[i*TW +: TW]] = thr_cnt[tid_q[i*TW +: TW]] + 1;
    end
    cap_ok = 1'b1;
    for (int t = 0; t < NT; t++) begin
      if (thr_cnt[t] > int'(cap_limit(cap_q, NS))) cap_ok = 1'b0;
    end
  end

  for (genvar s = 0; s < NS; s++) begin : g_slot_chk
    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(slot_grant[s*NE +: NE]));
    // R2
    vld_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_vld[s] == (|slot_grant[s*NE +: NE]));
  end

  // R2
  grant_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_grant & ~elig_q) == '0);

  // R2
  no_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_sum == $countones(any_grant));

  // R3
  slot_packed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_vld & (slot_vld + 1'b1)) == '0);

  // R4
  thread_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ok);
endmodule

bind issue_alloc issue_alloc_chk #(.NE(NE), .NS(NS), .TW(TW)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ent_valid  (ent_valid),
  .ent_ready  (ent_ready),
  .ent_tid    (ent_tid),
  .cap_mode   (cap_mode),
  .slot_vld   (slot_vld),
  .slot_grant (slot_grant)
);

// File: tb/test_issue_alloc.sv
module test_issue_alloc;
  localparam int NE = 32;
  localparam int NS = 8;
  localparam int TW = 3;
  localparam int AW = 5;
  localparam time CLK_PERIOD = 10ns;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NE-1:0]    ent_valid, ent_ready, ent_branch, ent_spec;
  logic [NE*TW-1:0] ent_tid;
  logic [NE*AW-1:0] ent_age;
  logic [1:0]       cap_mode, order_mode;
  logic [NS-1:0]    slot_vld;
  logic [NS*NE-1:0] slot_grant;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  issue_alloc i_issue_alloc (
    .clk(clk), .rst_n(rst_n), .ent_valid(ent_valid), .ent_ready(ent_ready),
    .ent_tid(ent_tid), .ent_age(ent_age), .ent_branch(ent_branch), .ent_spec(ent_spec),
    .cap_mode(cap_mode), .order_mode(order_mode), .slot_vld(slot_vld), .slot_grant(slot_grant)
  );

  task automatic clear_ents();
    ent_valid = '0; ent_ready = '0; ent_branch = '0; ent_spec = '0;
    ent_tid = '0; ent_age = '0;
  endtask

  task automatic set_ent(int i, int tid, int age, bit br, bit sp);
    ent_valid[i] = 1'b1; ent_ready[i] = 1'b1;
    ent_tid[i*TW +: TW] = TW'(tid);
    ent_age[i*AW +: AW] = AW'(age);
    ent_branch[i] = br; ent_spec[i] = sp;
  endtask

  // -1 means the slot must be empty
  task automatic expect_slots(int e [NS], string req);
    for (int k = 0; k < NS; k++) begin
      int ones = 0;
      int idx = -1;
      for (int i = 0; i < NE; i++) begin
        if (slot_grant[k*NE + i]) begin ones++; idx = i; end
      end
      checks++;
      if (e[k] < 0) begin
        if (slot_vld[k] || ones != 0) begin
          errors++;
          $display("FAIL %s slot %0d: vld=%0b idx=%0d expected empty", req, k, slot_vld[k], idx);
        end
      end else if (!slot_vld[k] || ones != 1 || idx != e[k]) begin
        errors++;
        $display("FAIL %s slot %0d: vld=%0b idx=%0d ones=%0d expected entry %0d",
                 req, k, slot_vld[k], idx, ones, e[k]);
      end
    end
  endtask

  // inputs set after a falling edge; result read at the next falling edge
  task automatic run_cycle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    expect_slots('{-1,-1,-1,-1,-1,-1,-1,-1}, "R1");
  endtask

  task automatic t_oldest();
    clear_ents(); cap_mode = 2'b11; order_mode = 2'b00;
    for (int i = 0; i < 10; i++) set_ent(i, i % 8, 20 - i, 0, 0);
    #(CLK_PERIOD/4);
    checks++;
    if (slot_vld != '0) begin
      errors++; $display("FAIL R9 early output: vld=%b expected 00000000", slot_vld);
    end
    run_cycle();
    expect_slots('{9,8,7,6,5,4,3,2}, "R5 R9");
  endtask

  task automatic t_tie_and_filter();
    clear_ents(); cap_mode = 2'b11; order_mode = 2'b00;
    set_ent(4, 1, 7, 0, 0);
    set_ent(2, 2, 7, 0, 0);
    set_ent(6, 3, 3, 0, 0);
    set_ent(1, 0, 0, 0, 0); ent_ready[1] = 1'b0;
    set_ent(0, 0, 0, 0, 0); ent_valid[0] = 1'b0;
    run_cycle();
    expect_slots('{6,2,4,-1,-1,-1,-1,-1}, "R2 R3 R5");
  endtask

  task automatic t_caps();
    // cap of two with three threads: six slots only
    clear_ents(); order_mode = 2'b00; cap_mode = 2'b01;
    for (int i = 0; i < NE; i++) set_ent(i, i % 3, i, 0, 0);
    run_cycle();
    expect_slots('{0,1,2,3,4,5,-1,-1}, "R10");
    // cap of two with four threads: full
    clear_ents();
    for (int i = 0; i < NE; i++) set_ent(i, i % 4, i, 0, 0);
    run_cycle();
    expect_slots('{0,1,2,3,4,5,6,7}, "R10 R4");
    // cap of one: threads own blocks of four entries
    clear_ents(); cap_mode = 2'b00;
    for (int i = 0; i < NE; i++) set_ent(i, i / 4, i, 0, 0);
    run_cycle();
    expect_slots('{0,4,8,12,16,20,24,28}, "R4 R8");
    // cap of four: threads own blocks of eight entries
    clear_ents(); cap_mode = 2'b10;
    for (int i = 0; i < NE; i++) set_ent(i, i / 8, i, 0, 0);
    run_cycle();
    expect_slots('{0,1,2,3,8,9,10,11}, "R4 R8");
    // unlimited: one thread takes every slot
    clear_ents(); cap_mode = 2'b11;
    for (int i = 0; i < NE; i++) set_ent(i, 5, i, 0, 0);
    run_cycle();
    expect_slots('{0,1,2,3,4,5,6,7}, "R4");
  endtask

  task automatic t_branch_first();
    clear_ents(); cap_mode = 2'b11; order_mode = 2'b01;
    for (int i = 0; i < 10; i++) set_ent(i, i % 8, i, (i == 5) || (i == 9), 0);
    run_cycle();
    expect_slots('{5,9,0,1,2,3,4,6}, "R6");
    order_mode = 2'b00;
    run_cycle();
    expect_slots('{0,1,2,3,4,5,6,7}, "R5");
  endtask

  task automatic t_spec_last();
    clear_ents(); cap_mode = 2'b11; order_mode = 2'b10;
    for (int i = 0; i < 10; i++) set_ent(i, i % 8, i, 0, i < 2);
    run_cycle();
    expect_slots('{2,3,4,5,6,7,8,9}, "R7");
    clear_ents();
    for (int i = 0; i < 4; i++) set_ent(i, i, i, 0, i < 2);
    run_cycle();
    expect_slots('{2,3,0,1,-1,-1,-1,-1}, "R7 R3");
    // both rules: speculative major key, branch minor key
    clear_ents(); order_mode = 2'b11;
    set_ent(0, 0, 0, 0, 1);
    set_ent(1, 1, 1, 0, 0);
    set_ent(2, 2, 2, 0, 0);
    set_ent(3, 3, 3, 1, 1);
    set_ent(4, 4, 4, 1, 0);
    set_ent(5, 5, 5, 0, 0);
    run_cycle();
    expect_slots('{4,1,2,5,3,0,-1,-1}, "R7 R6");
  endtask

  initial begin
    rst_n = 1'b0;
    clear_ents(); cap_mode = 2'b11; order_mode = 2'b00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_oldest();
    t_tie_and_filter();
    t_caps();
    t_branch_first();
    t_spec_last();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule